// File: doc/BRIEF.md
# Dual-Channel Input Capture Timer

This block measures the pulse widths of two external signals at the same time. Both channels share one free-running 16-bit counter. Software works out a width as the difference between two captured counter values. The counter and both input filters advance only when an external prescaler supplies a one-cycle count-enable pulse. Everything else runs on a single system clock.

Each input first passes through a two-flop synchronizer. It then goes to a sampling filter. The filter accepts a new level only after two consecutive count-enable samples agree on it, so short glitches are dropped. An accepted change that matches the channel's programmed edge type copies the counter into a capture register and raises a sticky interrupt flag. The mapping is crossed: input 0 loads capture register 1 and flag 1, and input 1 loads capture register 0 and flag 0. A counter wrap raises a sticky overflow flag. Software clears the flags by writing ones to the status register.

Register map, by read/write address:

| Address | Register |
|---------|----------|
| 0 | Mode |
| 1 | Edge select |
| 2 | Capture control |
| 3 | Status (write one to clear) |
| 4 | Counter (read only) |
| 5 | Capture register 0 (read only) |
| 6 | Capture register 1 (read only) |

The mode, edge-select and capture-control registers hold 8 bits and read back zero-extended.

Top module: `dual_capture_timer`

## Requirements
- R1: After reset, the counter, both capture registers, all three flags and the mode, edge-select and capture-control registers read as zero.
- R2: The counter steps by one on each count-enable pulse only while mode bits 3:2 equal 01. Otherwise it holds its value. A capture never clears or reloads it.
- R3: When the counter steps from FFFF to 0000, the overflow flag (status bit 2, output `ovf_flag`) is set and stays set until it is cleared.
- R4: When capture-control bit 2 is 1, an accepted valid edge on input 0 loads capture register 1 with the counter value it held just before that count-enable pulse, and sets flag 1 (status bit 1, output `irq1`).
- R5: When capture-control bit 0 is 1 and bit 1 is 0, an accepted valid edge on input 1 loads capture register 0 with that same counter value and sets flag 0 (status bit 0, output `irq0`).
- R6: Edge-select bits 5:4 govern input 0 and bits 7:6 govern input 1. The codes are 00 for a falling edge, 01 for a rising edge, 11 for both edges, and 10 for no capture.
- R7: An input is sampled after its two-flop synchronizer, on count-enable pulses only. A new level is accepted on the second consecutive sample that shows it. A pulse seen by at most one sample causes no capture.
- R8: Writing status (address 3) clears each flag whose data bit (2:0) is 1 and leaves the others unchanged. A flag set in the same cycle as its clear stays set.
- R9: Both channels may capture on the same count-enable pulse. Each register then receives the same counter value, and both flags are set.
- R10: When a channel's capture is disabled (capture-control bit 2 for input 0; bit 0 clear or bit 1 set for input 1), its capture register and flag stay unchanged. Writes to addresses 4 to 6 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | One-cycle count-enable pulse from the prescaler |
| in0 | input | 1 | Asynchronous measured input 0 |
| in1 | input | 1 | Asynchronous measured input 1 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 16 | Read data, combinational from rd_addr |
| irq0 | output | 1 | Flag 0: capture register 0 loaded |
| irq1 | output | 1 | Flag 1: capture register 1 loaded |
| ovf_flag | output | 1 | Counter overflow flag |

## Verification
A level change on an input reaches the filter two clocks later, through the synchronizer. The change is accepted on the second count-enable pulse that samples it. The capture register and flag then change on that same clock edge, so `rd_data` and the flags show the result at the following falling edge. Register writes and status clears take effect on the edge where `wr_en` is seen. The counter shows its new value one clock after each enabled pulse. The bench drives inputs just after a rising edge and advances a behavioural model on each rising edge with the values seen before it. It compares every output and the rotating read port at each falling edge, so every latency above is checked at the exact cycle it is due.

// File: rtl/dct_pkg.sv
package dct_pkg;

  typedef enum logic [1:0] {
    EDG_FALL = 2'b00,
    EDG_RISE = 2'b01,
    EDG_NONE = 2'b10,
    EDG_BOTH = 2'b11
  } edge_sel_e;

  localparam logic [2:0] A_MODE = 3'd0;
  localparam logic [2:0] A_EDGE = 3'd1;
  localparam logic [2:0] A_CAPC = 3'd2;
  localparam logic [2:0] A_STAT = 3'd3;
  localparam logic [2:0] A_CNT  = 3'd4;
  localparam logic [2:0] A_CAP0 = 3'd5;
  localparam logic [2:0] A_CAP1 = 3'd6;

  // True when an accepted change to level new_lvl matches the edge code.
  function automatic logic edge_match(input logic [1:0] sel, input logic new_lvl);
    logic m;
    case (edge_sel_e'(sel))
      EDG_FALL: m = ~new_lvl;
      EDG_RISE: m = new_lvl;
      EDG_BOTH: m = 1'b1;
      default:  m = 1'b0;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/dct_edge_filter.sv
module dct_edge_filter #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       smp_en,
  input  logic       pin,
  input  logic [1:0] sel,
  output logic       hit
);
  import dct_pkg::*;

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   sync_out;
  logic                   smp_q, smp_d;
  logic                   lvl_q, lvl_d;
  logic                   chg;

  assign sync_out = sync_q[SYNC_STAGES-1];

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], pin};
    smp_d  = smp_q;
    lvl_d  = lvl_q;
    chg    = 1'b0;
    if (smp_en) begin
      smp_d = sync_out;
      if ((sync_out == smp_q) && (sync_out != lvl_q)) begin
        lvl_d = sync_out;
        chg   = 1'b1;
      end
    end
  end

  assign hit = chg & edge_match(sel, sync_out);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      smp_q  <= 1'b0;
      lvl_q  <= 1'b0;
    end else begin
      sync_q <= sync_d;
      smp_q  <= smp_d;
      lvl_q  <= lvl_d;
    end
  end

  AST_FILT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_en |-> !hit); // R7
  AST_FILT_LVL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_en |=> $stable(lvl_q)); // R7

endmodule

// File: rtl/dct_free_counter.sv
module dct_free_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  logic [CNT_W-1:0] cnt_d;
  logic             step;

  assign step = tick & run;
  assign wrap = step & (&cnt);

  always_comb begin
    cnt_d = cnt;
    if (step) cnt_d = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick && run) |=> $stable(cnt)); // R2
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run) |=> (cnt == $past(cnt) + 1'b1)); // R2

endmodule

// File: rtl/dual_capture_timer.sv
module dual_capture_timer #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int CFG_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             in0,
  input  logic             in1,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CFG_W-1:0] wr_data,
  input  logic [2:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data,
  output logic             irq0,
  output logic             irq1,
  output logic             ovf_flag
);
  import dct_pkg::*;

  localparam int NCH   = 2;
  localparam int PAD_C = CNT_W - CFG_W;
  localparam int PAD_S = CNT_W - 3;

  logic [CFG_W-1:0] mode_q, mode_d;
  logic [CFG_W-1:0] edge_q, edge_d;
  logic [CFG_W-1:0] capc_q, capc_d;
  logic [CNT_W-1:0] cap0_q, cap0_d;
  logic [CNT_W-1:0] cap1_q, cap1_d;
  logic             f0_q, f0_d, f1_q, f1_d, ov_q, ov_d;

  logic [CNT_W-1:0] cnt;
  logic             wrap, run;
  logic [NCH-1:0]   pins, hit;
  logic             set0, set1;
  logic [2:0]       clr;

  assign run  = (mode_q[3:2] == 2'b01);
  assign pins = {in1, in0};

  dct_free_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (cnt_en),
    .run  (run),
    .cnt  (cnt),
    .wrap (wrap)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dct_edge_filter #(.SYNC_STAGES(SYNC_STAGES)) u_filt (
      .clk   (clk),
      .rst_n (rst_n),
      .smp_en(cnt_en),
      .pin   (pins[g]),
      .sel   (edge_q[4+2*g +: 2]),
      .hit   (hit[g])
    );
  end

  // Crossed mapping: input 0 feeds register 1, input 1 feeds register 0.
  assign set1 = hit[0] & capc_q[2];
  assign set0 = hit[1] & capc_q[0] & ~capc_q[1];
  assign clr  = (wr_en && wr_addr == A_STAT) ? wr_data[2:0] : 3'b000;

  always_comb begin
    mode_d = mode_q;
    edge_d = edge_q;
    capc_d = capc_q;
    if (wr_en) begin
      case (wr_addr)
        A_MODE:  mode_d = wr_data;
        A_EDGE:  edge_d = wr_data;
        A_CAPC:  capc_d = wr_data;
        default: ;
      endcase
    end
    cap0_d = set0 ? cnt : cap0_q;
    cap1_d = set1 ? cnt : cap1_q;
    f0_d   = set0 | (f0_q & ~clr[0]);
    f1_d   = set1 | (f1_q & ~clr[1]);
    ov_d   = wrap | (ov_q & ~clr[2]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      edge_q <= '0;
      capc_q <= '0;
      cap0_q <= '0;
      cap1_q <= '0;
      f0_q   <= 1'b0;
      f1_q   <= 1'b0;
      ov_q   <= 1'b0;
    end else begin
      mode_q <= mode_d;
      edge_q <= edge_d;
      capc_q <= capc_d;
      cap0_q <= cap0_d;
      cap1_q <= cap1_d;
      f0_q   <= f0_d;
      f1_q   <= f1_d;
      ov_q   <= ov_d;
    end
  end

  always_comb begin
    case (rd_addr)
      A_MODE:  rd_data = {{PAD_C{1'b0}}, mode_q};
      A_EDGE:  rd_data = {{PAD_C{1'b0}}, edge_q};
      A_CAPC:  rd_data = {{PAD_C{1'b0}}, capc_q};
      A_STAT:  rd_data = {{PAD_S{1'b0}}, ov_q, f1_q, f0_q};
      A_CNT:   rd_data = cnt;
      A_CAP0:  rd_data = cap0_q;
      A_CAP1:  rd_data = cap1_q;
      default: rd_data = '0;
    endcase
  end

  assign irq0     = f0_q;
  assign irq1     = f1_q;
  assign ovf_flag = ov_q;

  AST_CAP1_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (hit[0] && capc_q[2]) |=> (cap1_q == $past(cnt))); // R4
  AST_CAP0_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (hit[1] && capc_q[0] && !capc_q[1]) |=> (cap0_q == $past(cnt))); // R5
  AST_CAP0_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit[1] && capc_q[0] && !capc_q[1]) |=> $stable(cap0_q)); // R10
  AST_FLAG1_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (hit[0] && capc_q[2]) |=> irq1); // R8
  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && run && (&cnt)) |=> ovf_flag); // R3
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !(wr_en && wr_addr == A_STAT && wr_data[2])) |=> ovf_flag); // R3

endmodule

// File: tb/tb_dual_capture_timer.sv
module tb_dual_capture_timer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_en = 1'b0;
  logic        in0 = 1'b0, in1 = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        irq0, irq1, ovf_flag;

  int    total = 0, bad = 0;
  int    pdiv = 0, pcnt = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_capture_timer dut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .in0(in0), .in1(in1),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq0(irq0), .irq1(irq1), .ovf_flag(ovf_flag)
  );

  // Behavioural reference model.
  logic [1:0]  m_dl0, m_dl1;
  logic        m_s0, m_s1, m_l0, m_l1;
  logic [7:0]  m_mode, m_edge, m_capc;
  logic [15:0] m_cnt, m_cap0, m_cap1;
  logic        m_f0, m_f1, m_ov;

  function automatic logic sel_ok(input logic [1:0] s, input logic lv);
    if (s == 2'b11) return 1'b1;
    if (s == 2'b01) return lv;
    if (s == 2'b00) return !lv;
    return 1'b0;
  endfunction

  always @(posedge clk) begin
    logic a0, a1, e0, e1, st0, st1, ovs;
    logic [2:0] cl;
    if (!rst_n) begin
      m_dl0 = 0; m_dl1 = 0; m_s0 = 0; m_s1 = 0; m_l0 = 0; m_l1 = 0;
      m_mode = 0; m_edge = 0; m_capc = 0; m_cnt = 0; m_cap0 = 0; m_cap1 = 0;
      m_f0 = 0; m_f1 = 0; m_ov = 0;
    end else begin
      a0 = m_dl0[1]; a1 = m_dl1[1];
      m_dl0 = {m_dl0[0], in0}; m_dl1 = {m_dl1[0], in1};
      e0 = 0; e1 = 0;
      if (cnt_en) begin
        if (a0 == m_s0 && a0 != m_l0) begin m_l0 = a0; e0 = sel_ok(m_edge[5:4], a0); end
        if (a1 == m_s1 && a1 != m_l1) begin m_l1 = a1; e1 = sel_ok(m_edge[7:6], a1); end
        m_s0 = a0; m_s1 = a1;
      end
      st1 = e0 && m_capc[2];
      st0 = e1 && m_capc[0] && !m_capc[1];
      if (st1) m_cap1 = m_cnt;
      if (st0) m_cap0 = m_cnt;
      ovs = 0;
      if (cnt_en && m_mode[3:2] == 2'b01) begin
        if (m_cnt == 16'hFFFF) ovs = 1;
        m_cnt = m_cnt + 16'd1;
      end
      cl = (wr_en && wr_addr == 3'd3) ? wr_data[2:0] : 3'b000;
      m_f0 = st0 | (m_f0 & !cl[0]);
      m_f1 = st1 | (m_f1 & !cl[1]);
      m_ov = ovs | (m_ov & !cl[2]);
      if (wr_en) begin
        if (wr_addr == 3'd0) m_mode = wr_data;
        if (wr_addr == 3'd1) m_edge = wr_data;
        if (wr_addr == 3'd2) m_capc = wr_data;
      end
    end
  end

  function automatic logic [15:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return {8'h00, m_mode};
      3'd1: return {8'h00, m_edge};
      3'd2: return {8'h00, m_capc};
      3'd3: return {13'd0, m_ov, m_f1, m_f0};
      3'd4: return m_cnt;
      3'd5: return m_cap0;
      3'd6: return m_cap1;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Per-clock comparison against the model.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(rd_data == m_read(rd_addr), cur_req, rd_data, m_read(rd_addr));
      chk({irq0, irq1, ovf_flag} == {m_f0, m_f1, m_ov}, cur_req,
          {irq0, irq1, ovf_flag}, {m_f0, m_f1, m_ov});
    end
  end

  // Prescaler and rotating read address, driven just after each edge.
  always @(posedge clk) begin
    #1;
    rd_addr <= (rd_addr == 3'd6) ? 3'd0 : rd_addr + 3'd1;
    if (pdiv == 0) begin
      cnt_en <= 1'b0; pcnt = 0;
    end else if (pcnt >= pdiv - 1) begin
      cnt_en <= 1'b1; pcnt = 0;
    end else begin
      cnt_en <= 1'b0; pcnt++;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1 reset state
    cyc(3);
    for (int a = 0; a < 7; a++) begin
      rd_addr = 3'(a); #1;
      chk(rd_data == 16'h0, "R1", rd_data, 0);
    end
    chk({irq0, irq1, ovf_flag} == 3'b000, "R1", {irq0, irq1, ovf_flag}, 0);
    @(negedge clk); rst_n = 1'b1;
    cyc(4);

    // R2 counter holds when not in free-run mode, then runs
    cur_req = "R2"; pdiv = 3;
    wr(3'd0, 8'h08); cyc(20);
    wr(3'd0, 8'h04); cyc(30);

    // R4 / R5 / R6 crossed captures with rising on in0, falling on in1
    cur_req = "R4"; wr(3'd1, 8'h10); wr(3'd2, 8'h05);
    in0 = 1; cyc(20);
    chk(irq1 == 1'b1, "R4", irq1, 1);
    cur_req = "R6"; in0 = 0; in1 = 1; cyc(20);
    cur_req = "R5"; in1 = 0; cyc(20);
    chk(irq0 == 1'b1, "R5", irq0, 1);

    // R8 partial clear leaves the other flag set
    cur_req = "R8"; wr(3'd3, 8'h01); cyc(2);
    chk(irq0 == 1'b0 && irq1 == 1'b1, "R8", {irq0, irq1}, 2'b01);
    wr(3'd3, 8'h07); cyc(2);

    // R7 single-clock glitch on in0 with sparse sampling is rejected
    cur_req = "R7"; pdiv = 4;
    in0 = 1; cyc(1); in0 = 0; cyc(30);
    chk(irq1 == 1'b0, "R7", irq1, 0);

    // R6 both-edge and no-capture codes
    cur_req = "R6"; wr(3'd1, 8'hF0);
    in0 = 1; cyc(20); in1 = 1; cyc(20); in0 = 0; cyc(20); in1 = 0; cyc(20);
    wr(3'd3, 8'h07); wr(3'd1, 8'hA0);
    in0 = 1; in1 = 1; cyc(20); in0 = 0; in1 = 0; cyc(20);
    chk({irq0, irq1} == 2'b00, "R6", {irq0, irq1}, 0);

    // R9 simultaneous captures on both channels
    cur_req = "R9"; wr(3'd1, 8'hF0); cyc(4);
    in0 = 1; in1 = 1; cyc(20);
    chk({irq0, irq1} == 2'b11, "R9", {irq0, irq1}, 2'b11);

    // R10 disabled capture paths and read-only registers
    cur_req = "R10"; wr(3'd3, 8'h07); wr(3'd2, 8'h03);
    in0 = 0; in1 = 0; cyc(20);
    chk({irq0, irq1} == 2'b00, "R10", {irq0, irq1}, 0);
    wr(3'd2, 8'h00); in0 = 1; in1 = 1; cyc(20);
    chk({irq0, irq1} == 2'b00, "R10", {irq0, irq1}, 0);
    wr(3'd5, 8'h5A); wr(3'd4, 8'h33); cyc(10);

    // R3 overflow with count enable every cycle
    cur_req = "R3"; pdiv = 1; cyc(65600);
    chk(ovf_flag == 1'b1, "R3", ovf_flag, 1);
    wr(3'd3, 8'h04); cyc(3);
    chk(ovf_flag == 1'b0, "R3", ovf_flag, 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule